// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is the integer multiply unit of a processor core. It owns a 64-bit accumulator kept as two 32-bit halves: HI holds the upper word and LO the lower word. An operation starts with a one-cycle start pulse that carries an opcode, a signedness flag and two 32-bit operands. The product is built over several cycles by a shift-and-add multiplier that consumes a fixed number of multiplier bits per cycle. When the product is complete, the accumulator is overwritten, added to, subtracted from, or replaced with the negated product. The opcode can also ask for the new LO or the new HI word to be returned on a result port, which feeds the general register file.

Software moves data into and out of the accumulator through a separate write port for each half and a shared read port. The busy flag is high for the whole operation and acts as an interlock. A read request while busy raises a stall output, and writes to HI or LO while busy have no effect. A one-cycle done pulse marks the cycle in which the new HI/LO values and the result word first appear. Results and reads are sign-extended to the register width, which defaults to 64 bits.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset HI and LO are zero, and busy, done, resWe and resData are all zero.
- R2: With isUnsigned=0 both operands are sign-extended to 64 bits before multiplying; with isUnsigned=1 they are zero-extended. The product is taken modulo 2^64.
- R3: opCode[1:0] selects the accumulator update, with the accumulator formed as {HI,LO} (HI in bits 63:32). 00 writes the product, 01 adds the product, 10 subtracts the product, 11 writes zero minus the product. All arithmetic wraps modulo 2^64.
- R4: opCode[3:2] selects the result word. 01 returns the new LO and 10 returns the new HI, each with resWe=1 during the done cycle. 00 and 11 return nothing. resWe and resData are zero in every cycle that does not carry a returned word.
- R5: resData and rdData carry their 32-bit word sign-extended to the register width (default 64 bits).
- R6: Once start is accepted in an idle cycle, busy is high for exactly 2*DATA_W/STEP_W+1 cycles, starting in the next cycle (9 with the defaults). done is high for one cycle, in the first cycle with busy low. The new HI/LO values are visible in that same cycle.
- R7: A start pulse while busy is ignored, and the running operation completes with its original operands and opcode.
- R8: hiWe/loWe while idle load wrData into HI/LO, visible in the next cycle. While busy, both writes are ignored.
- R9: rdData shows HI when rdHi=1 and LO when rdHi=0. rdStall equals rdReq while busy and is 0 otherwise.
- R10: A HI/LO write in the same cycle as an accepted start takes effect, and the accumulate of that operation uses the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opCode | input | 4 | [1:0] accumulator update, [3:2] result word select |
| isUnsigned | input | 1 | 1 = zero-extend operands, 0 = sign-extend |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resWe | output | 1 | Result word valid for register write |
| resData | output | 64 | Returned HI or LO word, sign-extended |
| hiWe | input | 1 | Write HI from wrData |
| loWe | input | 1 | Write LO from wrData |
| wrData | input | 32 | Data for HI/LO writes |
| rdReq | input | 1 | Read request, used for the stall |
| rdHi | input | 1 | Read select: 1 = HI, 0 = LO |
| rdData | output | 64 | Selected half, sign-extended |
| rdStall | output | 1 | Read request blocked by busy |

## Verification
A direct HI/LO write and the latching of a new operation can happen in the same idle cycle. In that case the accumulate of the started operation must use the value just written, not the value from before the write. The bench provokes this by raising start together with hiWe for a multiply-add, and it judges the final {HI,LO} against the written value plus the product. It also places writes and a second start inside a busy window, and checks that neither changes the accumulator or the operation in progress.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  // accumulator update chosen by opCode[1:0]
  typedef enum logic [1:0] {
    ARITH_SET = 2'b00,
    ARITH_ADD = 2'b01,
    ARITH_SUB = 2'b10,
    ARITH_NEG = 2'b11
  } arith_e;

  // result word chosen by opCode[3:2]
  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_LO   = 2'b01,
    RES_HI   = 2'b10,
    RES_RSVD = 2'b11
  } resSel_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;    // latch operands and opcode
    logic step;    // one shift-add iteration
    logic commit;  // write new accumulator and result
  } macStrobe_t;

endpackage

// File: rtl/hilo_mac_ctrl.sv
module hilo_mac_ctrl
  import hilo_mac_pkg::*;
#(
  parameter int NCHUNK = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output macStrobe_t strb
);

  localparam int CNT_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCHUNK - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_e;

  ctrlState_e state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb.load   = start && (state == ST_IDLE);
    strb.step   = (state == ST_RUN);
    strb.commit = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.commit;
      case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (strb.load) state <= ST_RUN;
        end
        ST_RUN: begin
          if (stepCnt == LAST) begin
            state   <= ST_FIN;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: completion pulse lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done appears exactly when busy has just dropped
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/hilo_mac_dpath.sv
module hilo_mac_dpath
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 64,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobe_t        strb,
  input  logic              busy,
  input  logic [3:0]        opCode,
  input  logic              isUnsigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              hiWe,
  input  logic              loWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdHi,
  output logic [REG_W-1:0]  rdData,
  output logic              resWe,
  output logic [REG_W-1:0]  resData
);

  localparam int ACC_W = 2 * DATA_W;

  logic [DATA_W-1:0] hiReg, loReg;
  logic [ACC_W-1:0]  aSh, bSh, prod, partial, accNow, accNew;
  arith_e            kindR;
  resSel_e           selR;
  logic              resIsHi;
  logic              wrOk;

  assign wrOk   = !busy;
  assign accNow = {hiReg, loReg};

  // partial product for one iteration; single-bit steps need no multiplier
  generate
    if (STEP_W == 1) begin : g_bit_step
      assign partial = bSh[0] ? aSh : '0;
    end else begin : g_chunk_step
      assign partial = aSh * ACC_W'(bSh[STEP_W-1:0]);
    end
  endgenerate

  always_comb begin
    case (kindR)
      ARITH_SET: accNew = prod;
      ARITH_ADD: accNew = accNow + prod;
      ARITH_SUB: accNew = accNow - prod;
      default:   accNew = '0 - prod;
    endcase
  end

  // operand registers and iterative product
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aSh   <= '0;
      bSh   <= '0;
      prod  <= '0;
      kindR <= ARITH_SET;
      selR  <= RES_NONE;
    end else if (strb.load) begin
      aSh   <= isUnsigned ? ACC_W'(opA) : ACC_W'($signed(opA));
      bSh   <= isUnsigned ? ACC_W'(opB) : ACC_W'($signed(opB));
      prod  <= '0;
      kindR <= arith_e'(opCode[1:0]);
      selR  <= resSel_e'(opCode[3:2]);
    end else if (strb.step) begin
      prod <= prod + partial;
      aSh  <= aSh << STEP_W;
      bSh  <= bSh >> STEP_W;
    end
  end

  // accumulator halves
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strb.commit) begin
      hiReg <= accNew[ACC_W-1:DATA_W];
      loReg <= accNew[DATA_W-1:0];
    end else begin
      if (hiWe && wrOk) hiReg <= wrData;
      if (loWe && wrOk) loReg <= wrData;
    end
  end

  // result write-back port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resWe   <= 1'b0;
      resData <= '0;
      resIsHi <= 1'b0;
    end else begin
      resWe   <= 1'b0;
      resData <= '0;
      resIsHi <= 1'b0;
      if (strb.commit) begin
        if (selR == RES_LO) begin
          resWe   <= 1'b1;
          resData <= REG_W'($signed(accNew[DATA_W-1:0]));
        end else if (selR == RES_HI) begin
          resWe   <= 1'b1;
          resIsHi <= 1'b1;
          resData <= REG_W'($signed(accNew[ACC_W-1:DATA_W]));
        end
      end
    end
  end

  assign rdData = rdHi ? REG_W'($signed(hiReg)) : REG_W'($signed(loReg));

  // R8: while busy, only the commit may change the accumulator
  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> ($stable(hiReg) && $stable(loReg)));

  // R4: a returned HI word agrees with the HI register
  a_r4_res_hi_match: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && resIsHi) |-> (resData[DATA_W-1:0] == hiReg));

  // R4: a returned LO word agrees with the LO register
  a_r4_res_lo_match: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && !resIsHi) |-> (resData[DATA_W-1:0] == loReg));

  // R4: no returned word means a quiet result port
  a_r4_res_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resWe |-> (resData == '0));

endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 64,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        opCode,
  input  logic              isUnsigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic              resWe,
  output logic [REG_W-1:0]  resData,
  input  logic              hiWe,
  input  logic              loWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  input  logic              rdHi,
  output logic [REG_W-1:0]  rdData,
  output logic              rdStall
);

  localparam int NCHUNK = (2 * DATA_W) / STEP_W;

  macStrobe_t strb;

  hilo_mac_ctrl #(.NCHUNK(NCHUNK)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .strb  (strb)
  );

  hilo_mac_dpath #(.DATA_W(DATA_W), .REG_W(REG_W), .STEP_W(STEP_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .opCode     (opCode),
    .isUnsigned (isUnsigned),
    .opA        (opA),
    .opB        (opB),
    .hiWe       (hiWe),
    .loWe       (loWe),
    .wrData     (wrData),
    .rdHi       (rdHi),
    .rdData     (rdData),
    .resWe      (resWe),
    .resData    (resData)
  );

  assign rdStall = rdReq && busy;

endmodule

// File: tb/hilo_mac_unit_tb.sv
module hilo_mac_unit_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, start, isUnsigned, hiWe, loWe, rdReq, rdHi;
  logic [3:0]  opCode;
  logic [31:0] opA, opB, wrData;
  logic        busy, done, resWe, rdStall;
  logic [63:0] resData, rdData;

  hilo_mac_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .isUnsigned(isUnsigned),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .resWe(resWe), .resData(resData),
    .hiWe(hiWe), .loWe(loWe), .wrData(wrData), .rdReq(rdReq), .rdHi(rdHi),
    .rdData(rdData), .rdStall(rdStall)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cycles = 0;

  // behavioural reference state
  logic [31:0] mHi, mLo, mA, mB;
  logic [3:0]  mOp;
  logic        mUns, mDone, mResWe;
  logic [63:0] mRes;
  int          mLeft;
  localparam int LATENCY = 9;

  logic [63:0] lastRes;
  logic        lastWe;

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model advances on each edge, then compares late in the cycle
  always @(posedge clk) begin
    logic [63:0] ea, eb, p, acc, n;
    if (!rstN) begin
      mHi = 0; mLo = 0; mLeft = 0; mDone = 0; mResWe = 0; mRes = 0;
      mA = 0; mB = 0; mOp = 0; mUns = 0;
    end else begin
      mDone = 0; mResWe = 0; mRes = 0;
      if (mLeft == 0) begin
        if (hiWe) mHi = wrData;
        if (loWe) mLo = wrData;
        if (start) begin
          mA = opA; mB = opB; mOp = opCode; mUns = isUnsigned; mLeft = LATENCY;
        end
      end else begin
        mLeft--;
        if (mLeft == 0) begin
          ea  = mUns ? {32'b0, mA} : sx(mA);
          eb  = mUns ? {32'b0, mB} : sx(mB);
          p   = ea * eb;
          acc = {mHi, mLo};
          case (mOp[1:0])
            2'b00: n = p;
            2'b01: n = acc + p;
            2'b10: n = acc - p;
            default: n = 64'd0 - p;
          endcase
          mHi = n[63:32]; mLo = n[31:0]; mDone = 1;
          if (mOp[3:2] == 2'b01) begin mResWe = 1; mRes = sx(n[31:0]); end
          if (mOp[3:2] == 2'b10) begin mResWe = 1; mRes = sx(n[63:32]); end
        end
      end
    end
    #15;
    if (rstN && !finished) begin
      chk("R6 busy", {63'b0, busy}, {63'b0, mLeft != 0});
      chk("R6 done", {63'b0, done}, {63'b0, mDone});
      chk("R4 resWe", {63'b0, resWe}, {63'b0, mResWe});
      chk("R4/R5 resData", resData, mRes);
      chk("R9 rdData", rdData, rdHi ? sx(mHi) : sx(mLo));
      chk("R9 rdStall", {63'b0, rdStall}, {63'b0, rdReq && (mLeft != 0)});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #16;
  endtask

  task automatic waitDone();
    lastWe = 0; lastRes = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (done) begin
        lastRes = resData; lastWe = resWe;
        break;
      end
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic uns,
                       input logic [31:0] a, input logic [31:0] b);
    opCode = op; isUnsigned = uns; opA = a; opB = b; start = 1;
    tick();
    start = 0;
  endtask

  task automatic runOp(input logic [3:0] op, input logic uns,
                       input logic [31:0] a, input logic [31:0] b);
    issue(op, uns, a, b);
    waitDone();
  endtask

  task automatic readAcc(output logic [63:0] hiV, output logic [63:0] loV);
    rdHi = 1; #1; hiV = rdData;
    rdHi = 0; #1; loV = rdData;
  endtask

  task automatic setAcc(input logic [31:0] h, input logic [31:0] l);
    hiWe = 1; loWe = 0; wrData = h; tick();
    hiWe = 0; loWe = 1; wrData = l; tick();
    loWe = 0;
  endtask

  initial begin
    logic [63:0] h, l;
    rstN = 0; start = 0; opCode = 0; isUnsigned = 0; opA = 0; opB = 0;
    hiWe = 0; loWe = 0; wrData = 0; rdReq = 0; rdHi = 0;
    repeat (3) tick();
    rstN = 1;
    tick();

    // R1 reset state
    readAcc(h, l);
    chk("R1 HI after reset", h, 64'd0);
    chk("R1 LO after reset", l, 64'd0);
    chk("R1 busy/done/resWe", {61'b0, busy, done, resWe}, 64'd0);
    chk("R1 resData", resData, 64'd0);

    // R8 idle writes, R5 sign extension on reads
    setAcc(32'h8000_0001, 32'h1111_2222);
    readAcc(h, l);
    chk("R8/R5 HI write", h, 64'hFFFF_FFFF_8000_0001);
    chk("R8 LO write", l, 64'h0000_0000_1111_2222);

    // R2 signed and unsigned extension
    runOp(4'b0000, 0, 32'hFFFF_FFFD, 32'd7);
    readAcc(h, l);
    chk("R2 signed HI", h[31:0], 64'hFFFF_FFFF);
    chk("R2 signed LO", l[31:0], 64'hFFFF_FFEB);
    chk("R4 plain no result", {63'b0, lastWe}, 64'd0);
    runOp(4'b0000, 1, 32'hFFFF_FFFD, 32'd7);
    readAcc(h, l);
    chk("R2 unsigned HI", h[31:0], 64'h6);
    chk("R2 unsigned LO", l[31:0], 64'hFFFF_FFEB);

    // R3 add with wrap
    setAcc(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    runOp(4'b0001, 0, 32'd1, 32'd1);
    readAcc(h, l);
    chk("R3 add wrap", {h[31:0], l[31:0]}, 64'h8000_0000_0000_0000);

    // R3 subtract unsigned from zero
    setAcc(32'd0, 32'd0);
    runOp(4'b0010, 1, 32'd2, 32'd3);
    readAcc(h, l);
    chk("R3 sub", {h[31:0], l[31:0]}, 64'hFFFF_FFFF_FFFF_FFFA);

    // R3 negate with HI returned (R4)
    runOp(4'b1011, 0, 32'h0001_0000, 32'hFFFF_0000);
    readAcc(h, l);
    chk("R3 negate", {h[31:0], l[31:0]}, 64'h0000_0001_0000_0000);
    chk("R4 HI returned", lastRes, 64'h1);
    chk("R4 HI resWe", {63'b0, lastWe}, 64'd1);

    // R4/R5 accumulate with LO returned, sign-extended
    setAcc(32'd1, 32'd0);
    runOp(4'b0101, 0, 32'hFFFF_FFFF, 32'd1);
    chk("R4/R5 LO returned", lastRes, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4 subtract-accumulate with HI returned, unsigned
    runOp(4'b1010, 1, 32'h8000_0000, 32'd2);
    chk("R4/R5 HI of msac", lastRes, 64'hFFFF_FFFF_FFFF_FFFF);
    readAcc(h, l);
    chk("R3 msac LO", l[31:0], 64'hFFFF_FFFF);

    // R4 reserved selector returns nothing
    runOp(4'b1100, 0, 32'd5, 32'd5);
    chk("R4 reserved select", {63'b0, lastWe}, 64'd0);

    // R6 latency count
    issue(4'b0000, 0, 32'd3, 32'd3);
    begin
      int n = 1;
      while (busy && n < 40) begin tick(); n++; end
      chk("R6 busy length", 64'(n - 1), 64'd9);
    end

    // R7 start while busy ignored, R9 stall while busy
    issue(4'b0000, 0, 32'd2, 32'd3);
    tick();
    rdReq = 1;
    issue(4'b0001, 1, 32'd100, 32'd100);
    chk("R9 stall while busy", {63'b0, rdStall}, 64'd1);
    waitDone();
    chk("R9 no stall idle", {63'b0, rdStall}, 64'd0);
    rdReq = 0;
    readAcc(h, l);
    chk("R7 busy start ignored", {h[31:0], l[31:0]}, 64'd6);

    // R8 write while busy ignored
    setAcc(32'd0, 32'd5);
    issue(4'b0001, 1, 32'd1, 32'd1);
    hiWe = 1; loWe = 1; wrData = 32'hDEAD_BEEF; tick();
    hiWe = 0; loWe = 0;
    waitDone();
    readAcc(h, l);
    chk("R8 busy write ignored", {h[31:0], l[31:0]}, 64'd6);

    // R10 write in the same cycle as start
    setAcc(32'd0, 32'd0);
    hiWe = 1; wrData = 32'd7;
    issue(4'b0001, 1, 32'd2, 32'd2);
    hiWe = 0;
    waitDone();
    readAcc(h, l);
    chk("R10 same-cycle write", {h[31:0], l[31:0]}, 64'h0000_0007_0000_0004);

    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule